// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block sorts each virtual address issued by a 64-bit processor core into one of three outcomes. The address can go straight to a fixed physical window, in which case the block also computes the physical address. It can need a lookup in the translation buffer. Or it can violate the current privilege level, in which case the block reports an address error. The core presents the address, a write flag and the relevant status fields together with a request strobe. One clock later the block returns the outcome, the physical address, the effective privilege level and the wide-addressing flag, marked by a single-cycle valid pulse.

The privilege level used for the decision comes from the 2-bit mode field, but either exception-level bit forces kernel level. The top-bit window, the low 2 GB region and the kernel direct windows are checked in a fixed priority order. A short 32-bit address with bit 31 set is widened by sign extension before the upper checks.

Top module: `vaddr_seg_decoder`

## Requirements
- R1: The reported mode `rsp_mode` is 00 (kernel) when `st_exl` or `st_erl` is 1. Otherwise it is 00 when `st_ksu`=00, 01 (supervisor) when `st_ksu`=01, and 10 (user) when `st_ksu` is 10 or 11.
- R2: `rsp_x64` equals `st_kx` at kernel level, `st_sx` at supervisor level and `st_ux` at user level.
- R3: An address whose bits [63:62] are 10 gives `rsp_kind`=0 (unmapped) and `rsp_paddr` equal to the low 44 address bits, zero-extended, at every level. This check wins over all the others.
- R4: Any other address at or below 0x7FFFFFFF gives `rsp_kind`=1 (translate) at every level.
- R5: An address with bits [63:32] all zero and bit 31 set is sign-extended to 64 bits before the checks of R6 to R8. No other address is changed.
- R6: At kernel level, an extended address from 0xFFFFFFFF80000000 to 0xFFFFFFFFBFFFFFFF gives `rsp_kind`=0 and `rsp_paddr` equal to its low 29 bits.
- R7: At kernel level, every other address above 0x7FFFFFFF gives `rsp_kind`=1.
- R8: At supervisor or user level, every address above 0x7FFFFFFF that R3 does not cover gives `rsp_kind`=2 (error). `rsp_err` is then 2 (store) when `req_write`=1 and 1 (load) when it is 0.
- R9: A request sampled on a rising edge sets `rsp_valid` to 1 for exactly the following cycle. With no request, `rsp_valid` is 0. Reset clears every output to zero.
- R10: `rsp_err` is 0 for every result except an error. `rsp_paddr` is 0 for every result except an unmapped one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 64 | Virtual address |
| req_write | input | 1 | 1 for a store, 0 for a load |
| st_ksu | input | 2 | Privilege mode field |
| st_exl | input | 1 | Exception level |
| st_erl | input | 1 | Error level |
| st_ux | input | 1 | Wide addressing enable, user |
| st_sx | input | 1 | Wide addressing enable, supervisor |
| st_kx | input | 1 | Wide addressing enable, kernel |
| rsp_valid | output | 1 | Result strobe, one cycle |
| rsp_kind | output | 2 | 0 unmapped, 1 translate, 2 error |
| rsp_err | output | 2 | 0 none, 1 load error, 2 store error |
| rsp_paddr | output | 64 | Physical address for unmapped results |
| rsp_mode | output | 2 | Effective privilege level |
| rsp_x64 | output | 1 | Wide addressing flag |

## Verification
Every result, including the valid strobe, is due exactly one rising edge after the edge that samples the request. The bench drives each request on a falling edge and reads all outputs on the next falling edge, half a period after the capturing edge. It then drops the strobe and reads `rsp_valid` one falling edge later to confirm the pulse has ended. The reset values are read before any request is made.

// File: rtl/vaddr_seg_decoder.sv
module vaddr_seg_decoder #(
  parameter int PHYS_W = 44,
  parameter int KWIN_W = 29
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [63:0] req_vaddr,
  input  logic        req_write,
  input  logic [1:0]  st_ksu,
  input  logic        st_exl,
  input  logic        st_erl,
  input  logic        st_ux,
  input  logic        st_sx,
  input  logic        st_kx,
  output logic        rsp_valid,
  output logic [1:0]  rsp_kind,
  output logic [1:0]  rsp_err,
  output logic [63:0] rsp_paddr,
  output logic [1:0]  rsp_mode,
  output logic        rsp_x64
);

  localparam logic [1:0] K_UNMAP = 2'd0;
  localparam logic [1:0] K_XLATE = 2'd1;
  localparam logic [1:0] K_ERROR = 2'd2;
  localparam logic [1:0] E_NONE  = 2'd0;
  localparam logic [1:0] E_LOAD  = 2'd1;
  localparam logic [1:0] E_STORE = 2'd2;
  localparam logic [1:0] M_KERN  = 2'b00;
  localparam logic [1:0] M_SUPV  = 2'b01;
  localparam logic [1:0] M_USER  = 2'b10;
  localparam logic [33:0] KWIN_TAG = 34'h3_FFFF_FFFE;

  logic        kern;
  logic [1:0]  mode_c;
  logic        x64_c;
  logic        phys_win;
  logic        low_half;
  logic [63:0] va_ext;
  logic        kwin_hit;
  logic [1:0]  kind_c;
  logic [1:0]  err_c;
  logic [63:0] pa_c;

  assign kern     = st_exl | st_erl | (st_ksu == M_KERN);
  assign mode_c   = kern ? M_KERN : (st_ksu == M_SUPV ? M_SUPV : M_USER);
  assign x64_c    = kern ? st_kx : (mode_c == M_SUPV ? st_sx : st_ux);
  assign phys_win = req_vaddr[63:62] == 2'b10;
  assign low_half = req_vaddr[63:31] == '0;
  assign va_ext   = (req_vaddr[63:32] == '0 && req_vaddr[31])
                    ? {32'hFFFF_FFFF, req_vaddr[31:0]} : req_vaddr;
  assign kwin_hit = va_ext[63:30] == KWIN_TAG;

  always_comb begin
    kind_c = K_XLATE;
    err_c  = E_NONE;
    pa_c   = '0;
    if (phys_win) begin
      kind_c = K_UNMAP;
      pa_c   = {{(64-PHYS_W){1'b0}}, req_vaddr[PHYS_W-1:0]};
    end else if (low_half) begin
      kind_c = K_XLATE;
    end else if (kern) begin
      if (kwin_hit) begin
        kind_c = K_UNMAP;
        pa_c   = {{(64-KWIN_W){1'b0}}, va_ext[KWIN_W-1:0]};
      end
    end else begin
      kind_c = K_ERROR;
      err_c  = req_write ? E_STORE : E_LOAD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_kind  <= K_UNMAP;
      rsp_err   <= E_NONE;
      rsp_paddr <= '0;
      rsp_mode  <= M_KERN;
      rsp_x64   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_kind  <= kind_c;
        rsp_err   <= err_c;
        rsp_paddr <= pa_c;
        rsp_mode  <= mode_c;
        rsp_x64   <= x64_c;
      end
    end
  end

  p_pulse_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_req_no_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_exc_level_kernel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (st_exl || st_erl)) |=> rsp_mode == M_KERN);
  p_low_region_xlate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_vaddr[63:31] == '0) |=> rsp_kind == K_XLATE);
  p_err_only_on_error_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind != K_ERROR) |-> rsp_err == E_NONE);
  p_error_not_kernel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == K_ERROR) |-> rsp_mode != M_KERN);
  p_paddr_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == K_UNMAP) |-> rsp_paddr[63:PHYS_W] == '0);

endmodule

// File: tb/vaddr_seg_decoder_tb_top.sv
module vaddr_seg_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [63:0] va;
    logic        wr;
    logic [1:0]  ksu;
    logic        exl, erl, ux, sx, kx;
    logic [1:0]  kind, err;
    logic [63:0] pa;
    logic [1:0]  mode;
    logic        x64;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_0000_0000_1000, 1'b0, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 2'd0, 64'h0, 2'b10, 1'b1},
    '{64'h0000_0000_7FFF_FFFF, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 64'h0, 2'b10, 1'b0},
    '{64'h0000_0000_8000_0000, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 64'h0, 2'b00, 1'b1},
    '{64'h0000_0000_A123_4567, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 64'h0123_4567, 2'b00, 1'b0},
    '{64'hFFFF_FFFF_BFFF_FFFF, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 64'h1FFF_FFFF, 2'b00, 1'b1},
    '{64'hFFFF_FFFF_C000_0000, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 64'h0, 2'b00, 1'b0},
    '{64'h9000_0000_1F60_0050, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 64'h1F60_0050, 2'b10, 1'b0},
    '{64'hBFFF_FFFF_FFFF_FFFF, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 64'h0FFF_FFFF_FFFF, 2'b00, 1'b0},
    '{64'h0000_0000_8000_0000, 1'b0, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 2'd1, 64'h0, 2'b10, 1'b1},
    '{64'hFFFF_FFFF_8000_0000, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 2'd2, 64'h0, 2'b01, 1'b1},
    '{64'hFFFF_FFFF_9000_0000, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 64'h1000_0000, 2'b00, 1'b1},
    '{64'h4000_0000_0000_0000, 1'b0, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1, 2'd0, 64'h0, 2'b00, 1'b0},
    '{64'h0000_0000_0000_2000, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 2'd0, 64'h0, 2'b10, 1'b0},
    '{64'h0000_0001_8000_0000, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 64'h0, 2'b00, 1'b0},
    '{64'h0000_0000_8000_0000, 1'b1, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 2'd2, 64'h0, 2'b10, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  st_ksu = 2'b00;
  logic        st_exl = 1'b0, st_erl = 1'b0, st_ux = 1'b0, st_sx = 1'b0, st_kx = 1'b0;
  logic        rsp_valid;
  logic [1:0]  rsp_kind, rsp_err, rsp_mode;
  logic [63:0] rsp_paddr;
  logic        rsp_x64;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vaddr_seg_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .st_ksu(st_ksu), .st_exl(st_exl), .st_erl(st_erl),
    .st_ux(st_ux), .st_sx(st_sx), .st_kx(st_kx), .rsp_valid(rsp_valid),
    .rsp_kind(rsp_kind), .rsp_err(rsp_err), .rsp_paddr(rsp_paddr),
    .rsp_mode(rsp_mode), .rsp_x64(rsp_x64)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v, input int idx);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = v.va; req_write = v.wr; st_ksu = v.ksu;
    st_exl = v.exl; st_erl = v.erl; st_ux = v.ux; st_sx = v.sx; st_kx = v.kx;
    @(negedge clk);
    req_valid = 1'b0;
    check($sformatf("R9 valid v%0d", idx), {63'd0, rsp_valid}, 64'd1);
    check($sformatf("R3/R4/R6/R7/R8 kind v%0d", idx), {62'd0, rsp_kind}, {62'd0, v.kind});
    check($sformatf("R8/R10 err v%0d", idx), {62'd0, rsp_err}, {62'd0, v.err});
    check($sformatf("R3/R5/R6/R10 paddr v%0d", idx), rsp_paddr, v.pa);
    check($sformatf("R1 mode v%0d", idx), {62'd0, rsp_mode}, {62'd0, v.mode});
    check($sformatf("R2 x64 v%0d", idx), {63'd0, rsp_x64}, {63'd0, v.x64});
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset valid", {63'd0, rsp_valid}, 64'd0);
    check("R9 reset kind", {62'd0, rsp_kind}, 64'd0);
    check("R9 reset paddr", rsp_paddr, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle valid", {63'd0, rsp_valid}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i], i);
      @(negedge clk);
      check($sformatf("R9 pulse ends v%0d", i), {63'd0, rsp_valid}, 64'd0);
    end

    // R9: back-to-back requests each get a pulse
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 64'hFFFF_FFFF_8000_0040; st_ksu = 2'b00;
    st_exl = 1'b0; st_erl = 1'b0; req_write = 1'b0;
    @(negedge clk);
    check("R9 b2b first valid", {63'd0, rsp_valid}, 64'd1);
    check("R6 b2b first paddr", rsp_paddr, 64'h40);
    req_vaddr = 64'h0000_0000_0000_0040; st_ksu = 2'b10;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 b2b second valid", {63'd0, rsp_valid}, 64'd1);
    check("R4 b2b second kind", {62'd0, rsp_kind}, 64'd1);
    check("R10 b2b second paddr", rsp_paddr, 64'd0);
    @(negedge clk);
    check("R9 b2b end", {63'd0, rsp_valid}, 64'd0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule